// File: doc/BRIEF.md
# Lockable Cache Way-Replacement Selector

This block chooses where a cache line goes in a four-way set-associative operand cache that can pin lines in place. It holds a 32-bit control word with a global lock switch and, for ways 2 and 3 only, a "lock" bit and a "load" bit. A locked way is kept away from ordinary replacement. A prefetch that misses can be sent into a locked way when both that way's bits are set, which is how software places pinned lines.

Each lookup gives the block a valid flag, a prefetch flag, the hit result with the hit way, and the set's recency order. The block then says whether a fill is needed and which way to use. The decision is available in the same cycle on the combinational outputs. A registered copy with a one-cycle strobe follows on the next clock. The tag and data arrays, refill and recency bookkeeping live outside the block.

Top module: `lockway_victim_sel`

## Requirements
- R1: While reset is held and after it is released, `cfg_rdata` reads 0 and `res_valid` is 0 until an access is presented.
- R2: A write on `cfg_wr_en` is visible on `cfg_rdata` after the next clock edge. Only bit 16 (lock switch), bit 9 (way-3 load), bit 8 (way-3 lock), bit 1 (way-2 load) and bit 0 (way-2 lock) keep written values. Every other bit reads 0. Without a write, the register holds its value.
- R3: When a valid access hits, `fill_need` is 0 and `fill_way` equals `acc_hit_way`, whatever the control bits and prefetch flag are.
- R4: With the lock switch at 0, a valid miss fills the least-recently-used way, `lru_order[1:0]`. The load and lock bits have no effect. `lru_order` packs four 2-bit way numbers, with entry 0 in bits [1:0] being least recent and entry 3 in bits [7:6] being most recent.
- R5: With the lock switch at 1, a non-prefetch miss fills the first way in `lru_order`, from entry 0 upward, that is not locked. Way 3 counts as locked when bit 8 is set, and way 2 when bit 0 is set. Ways 0 and 1 are never locked.
- R6: With the lock switch at 1, a prefetch miss fills way 3 when bits 9 and 8 are both set. Otherwise it fills way 2 when bits 1 and 0 are both set.
- R7: If both load-and-lock pairs are set at once (a disallowed setting), a prefetch miss goes to way 3.
- R8: With the lock switch at 1, a prefetch miss with neither pair fully set picks its way exactly as in R5.
- R9: `res_valid` is 1 in the cycle after a cycle with `acc_valid` high, and 0 otherwise. `res_fill` and `res_way` then carry that earlier cycle's `fill_need` and `fill_way`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read value |
| acc_valid | input | 1 | Lookup result present this cycle |
| acc_is_pref | input | 1 | Access comes from a prefetch |
| acc_hit | input | 1 | Lookup hit |
| acc_hit_way | input | 2 | Way that hit |
| lru_order | input | 8 | Recency order, entry 0 least recent |
| fill_need | output | 1 | Combinational: a line fill is required |
| fill_way | output | 2 | Combinational: way to fill, or hit way |
| res_valid | output | 1 | Registered result strobe |
| res_fill | output | 1 | Registered fill flag |
| res_way | output | 2 | Registered way |

## Verification
The in-design properties assume that `lru_order` always holds the four way numbers as a permutation. Under that assumption an unlocked way always exists, and the scan always finds a candidate. They also assume that `acc_hit_way` is only meaningful while `acc_hit` is high. The stimulus only ever drives permutations of 0..3. It sweeps all 32 settings of the five control bits, including the disallowed double-load case, with hits in every way and misses, for both prefetch and plain accesses. Junk is written into the read-only bits on every configuration write.

// File: rtl/lockway_pkg.sv
package lockway_pkg;

   // Decoded view of the writable control bits
   typedef struct packed {
      logic en;        // global lock switch
      logic hi_load;   // top way: prefetch may load into it
      logic hi_lock;   // top way: excluded from normal replacement
      logic lo_load;   // second-top way: prefetch may load into it
      logic lo_lock;   // second-top way: excluded from normal replacement
   } lock_cfg_t;

   typedef enum logic [1:0] {
      SRC_KEEP   = 2'd0,
      SRC_FORCED = 2'd1,
      SRC_RECENT = 2'd2
   } way_src_e;

endpackage

// File: rtl/lockway_ctrl_reg.sv
module lockway_ctrl_reg
   import lockway_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter int EN_POS   = 16,
   parameter int HILD_POS = 9,
   parameter int HILK_POS = 8,
   parameter int LOLD_POS = 1,
   parameter int LOLK_POS = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output lock_cfg_t        cfg
);

   localparam logic [REG_W-1:0] WMASK =
      (REG_W'(1) << EN_POS)   | (REG_W'(1) << HILD_POS) |
      (REG_W'(1) << HILK_POS) | (REG_W'(1) << LOLD_POS) |
      (REG_W'(1) << LOLK_POS);

   generate
      if (EN_POS >= REG_W || HILD_POS >= REG_W || HILK_POS >= REG_W ||
          LOLD_POS >= REG_W || LOLK_POS >= REG_W) begin : g_bad_pos
         $error("lockway_ctrl_reg: bit position beyond register width");
      end
      if ($countones(WMASK) != 5) begin : g_bad_overlap
         $error("lockway_ctrl_reg: control bit positions overlap");
      end
   endgenerate

   lock_cfg_t cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_en) begin
         cfg_q.en      <= wdata[EN_POS];
         cfg_q.hi_load <= wdata[HILD_POS];
         cfg_q.hi_lock <= wdata[HILK_POS];
         cfg_q.lo_load <= wdata[LOLD_POS];
         cfg_q.lo_lock <= wdata[LOLK_POS];
      end
   end

   always_comb begin
      rdata           = '0;
      rdata[EN_POS]   = cfg_q.en;
      rdata[HILD_POS] = cfg_q.hi_load;
      rdata[HILK_POS] = cfg_q.hi_lock;
      rdata[LOLD_POS] = cfg_q.lo_load;
      rdata[LOLK_POS] = cfg_q.lo_lock;
   end

   assign cfg = cfg_q;

   AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rdata == ($past(wdata) & WMASK)));               // R2
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rdata));                                 // R2
   AST_CFG_RO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~WMASK) == '0);                                    // R2

endmodule

// File: rtl/lockway_lru_pick.sv
module lockway_lru_pick #(
   parameter int NUM_WAYS = 4,
   parameter int WAY_W    = $clog2(NUM_WAYS)
) (
   input  logic [NUM_WAYS*WAY_W-1:0] order,
   input  logic [NUM_WAYS-1:0]       allow,
   output logic [WAY_W-1:0]          way,
   output logic                      found
);

   generate
      if (NUM_WAYS < 2 || (1 << WAY_W) < NUM_WAYS) begin : g_bad_geom
         $error("lockway_lru_pick: way index too narrow for way count");
      end
   endgenerate

   logic [NUM_WAYS-1:0] cand;
   logic [WAY_W-1:0]    entry [NUM_WAYS];

   // One candidate flag per recency entry
   genvar gi;
   generate
      for (gi = 0; gi < NUM_WAYS; gi++) begin : g_entry
         assign entry[gi] = order[gi*WAY_W +: WAY_W];
         assign cand[gi]  = allow[entry[gi]];
      end
   endgenerate

   // Lowest entry (least recent) wins
   always_comb begin
      way   = '0;
      found = 1'b0;
      for (int i = NUM_WAYS - 1; i >= 0; i--) begin
         if (cand[i]) begin
            way   = entry[i];
            found = 1'b1;
         end
      end
   end

endmodule

// File: rtl/lockway_policy.sv
module lockway_policy
   import lockway_pkg::*;
#(
   parameter int NUM_WAYS = 4,
   parameter int WAY_W    = $clog2(NUM_WAYS),
   parameter bit HI_FIRST = 1'b1
) (
   input  lock_cfg_t                 cfg,
   input  logic                      valid,
   input  logic                      is_pref,
   input  logic                      hit,
   input  logic [WAY_W-1:0]          hit_way,
   input  logic [NUM_WAYS*WAY_W-1:0] order,
   output logic                      fill_need,
   output logic [WAY_W-1:0]          fill_way,
   output way_src_e                  src
);

   localparam int HI_WAY = NUM_WAYS - 1;
   localparam int LO_WAY = NUM_WAYS - 2;
   localparam logic [WAY_W-1:0] HI_IDX = WAY_W'(HI_WAY);
   localparam logic [WAY_W-1:0] LO_IDX = WAY_W'(LO_WAY);

   logic [NUM_WAYS-1:0] locked;
   logic [NUM_WAYS-1:0] allow;

   // Only the two top ways carry lock bits
   genvar gw;
   generate
      for (gw = 0; gw < NUM_WAYS; gw++) begin : g_lock
         if (gw == HI_WAY) begin : g_hi
            assign locked[gw] = cfg.en & cfg.hi_lock;
         end else if (gw == LO_WAY) begin : g_lo
            assign locked[gw] = cfg.en & cfg.lo_lock;
         end else begin : g_free
            assign locked[gw] = 1'b0;
         end
      end
   endgenerate

   assign allow = ~locked;

   logic [WAY_W-1:0] pick_way;
   logic             pick_found;

   lockway_lru_pick #(
      .NUM_WAYS (NUM_WAYS),
      .WAY_W    (WAY_W)
   ) u_pick (
      .order (order),
      .allow (allow),
      .way   (pick_way),
      .found (pick_found)
   );

   logic             hi_force;
   logic             lo_force;
   logic             any_force;
   logic [WAY_W-1:0] force_way;

   assign hi_force  = cfg.en & is_pref & cfg.hi_load & cfg.hi_lock;
   assign lo_force  = cfg.en & is_pref & cfg.lo_load & cfg.lo_lock;
   assign any_force = hi_force | lo_force;

   // Priority when both pairs are set (disallowed setting)
   generate
      if (HI_FIRST) begin : g_hi_first
         assign force_way = hi_force ? HI_IDX : LO_IDX;
      end else begin : g_lo_first
         assign force_way = lo_force ? LO_IDX : HI_IDX;
      end
   endgenerate

   always_comb begin
      if (hit) begin
         src = SRC_KEEP;
      end else if (any_force) begin
         src = SRC_FORCED;
      end else begin
         src = SRC_RECENT;
      end
   end

   always_comb begin
      fill_need = valid & ~hit;
      unique case (src)
         SRC_KEEP:   fill_way = hit_way;
         SRC_FORCED: fill_way = force_way;
         default:    fill_way = pick_found ? pick_way : '0;
      endcase
   end

endmodule

// File: rtl/lockway_victim_sel.sv
module lockway_victim_sel
   import lockway_pkg::*;
#(
   parameter int NUM_WAYS = 4,
   parameter int REG_W    = 32,
   parameter bit HI_FIRST = 1'b1,
   localparam int WAY_W   = $clog2(NUM_WAYS),
   localparam int ORD_W   = NUM_WAYS * WAY_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr_en,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   input  logic             acc_valid,
   input  logic             acc_is_pref,
   input  logic             acc_hit,
   input  logic [WAY_W-1:0] acc_hit_way,
   input  logic [ORD_W-1:0] lru_order,
   output logic             fill_need,
   output logic [WAY_W-1:0] fill_way,
   output logic             res_valid,
   output logic             res_fill,
   output logic [WAY_W-1:0] res_way
);

   generate
      if (NUM_WAYS != 4) begin : g_bad_ways
         $error("lockway_victim_sel: control layout fixes the way count at 4");
      end
      if (REG_W < 17) begin : g_bad_reg
         $error("lockway_victim_sel: register narrower than lock switch position");
      end
   endgenerate

   lock_cfg_t cfg;
   way_src_e  src;

   lockway_ctrl_reg #(
      .REG_W    (REG_W),
      .EN_POS   (16),
      .HILD_POS (9),
      .HILK_POS (8),
      .LOLD_POS (1),
      .LOLK_POS (0)
   ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (cfg_wr_en),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .cfg   (cfg)
   );

   lockway_policy #(
      .NUM_WAYS (NUM_WAYS),
      .WAY_W    (WAY_W),
      .HI_FIRST (HI_FIRST)
   ) u_policy (
      .cfg       (cfg),
      .valid     (acc_valid),
      .is_pref   (acc_is_pref),
      .hit       (acc_hit),
      .hit_way   (acc_hit_way),
      .order     (lru_order),
      .fill_need (fill_need),
      .fill_way  (fill_way),
      .src       (src)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_fill  <= 1'b0;
         res_way   <= '0;
      end else begin
         res_valid <= acc_valid;
         res_fill  <= acc_valid & fill_need;
         res_way   <= acc_valid ? fill_way : '0;
      end
   end

   localparam logic [WAY_W-1:0] TOP = WAY_W'(NUM_WAYS - 1);
   localparam logic [WAY_W-1:0] SEC = WAY_W'(NUM_WAYS - 2);

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |=> (!res_valid && cfg_rdata == '0));                               // R1
   AST_HIT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_hit) |-> (!fill_need && fill_way == acc_hit_way));       // R3
   AST_OFF_LRU: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_hit && !cfg_rdata[16]) |-> (fill_way == lru_order[1:0])); // R4
   AST_TOP_SHIELDED: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_hit && !acc_is_pref && cfg_rdata[16] && cfg_rdata[8])
      |-> (fill_way != TOP));                                                    // R5
   AST_SEC_SHIELDED: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_hit && !acc_is_pref && cfg_rdata[16] && cfg_rdata[0])
      |-> (fill_way != SEC));                                                    // R5
   AST_PREF_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_hit && acc_is_pref && cfg_rdata[16] && cfg_rdata[9] &&
       cfg_rdata[8] && HI_FIRST) |-> (fill_way == TOP));                         // R6
   AST_STROBE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> (res_valid && res_fill == $past(fill_need)
                     && res_way == $past(fill_way)));                            // R9
   AST_STROBE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !res_valid);                                                // R9

endmodule

// File: tb/tb_lockway_victim_sel.sv
`timescale 1ns/1ps
module tb_lockway_victim_sel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        acc_valid = 1'b0;
   logic        acc_is_pref = 1'b0;
   logic        acc_hit = 1'b0;
   logic [1:0]  acc_hit_way = '0;
   logic [7:0]  lru_order = 8'b11_10_01_00;
   logic        fill_need;
   logic [1:0]  fill_way;
   logic        res_valid;
   logic        res_fill;
   logic [1:0]  res_way;

   always #4 clk = ~clk;

   lockway_victim_sel dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wr_en   (cfg_wr_en),
      .cfg_wdata   (cfg_wdata),
      .cfg_rdata   (cfg_rdata),
      .acc_valid   (acc_valid),
      .acc_is_pref (acc_is_pref),
      .acc_hit     (acc_hit),
      .acc_hit_way (acc_hit_way),
      .lru_order   (lru_order),
      .fill_need   (fill_need),
      .fill_way    (fill_way),
      .res_valid   (res_valid),
      .res_fill    (res_fill),
      .res_way     (res_way)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 1'b0;

   typedef struct {
      logic       fill;
      logic [1:0] way;
      int         tag;
      string      req;
   } exp_t;
   exp_t sb[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Reference model written from the requirements
   function automatic logic [2:0] ref_dec(input logic [4:0] c, input bit pref,
                                           input bit hit, input logic [1:0] hw,
                                           input logic [7:0] ord);
      logic en, hld, hlk, lld, llk;
      {en, hld, hlk, lld, llk} = c;
      if (hit) return {1'b0, hw};
      if (!en) return {1'b1, ord[1:0]};
      if (pref && hld && hlk) return {1'b1, 2'd3};
      if (pref && lld && llk) return {1'b1, 2'd2};
      for (int i = 0; i < 4; i++) begin
         logic [1:0] w;
         w = ord[2*i +: 2];
         if (!((w == 2'd3 && hlk) || (w == 2'd2 && llk))) return {1'b1, w};
      end
      return 3'b000;
   endfunction

   function automatic string req_of(input logic [4:0] c, input bit pref, input bit hit);
      if (hit) return "R3";
      if (!c[4]) return "R4";
      if (pref && c[3] && c[2] && c[1] && c[0]) return "R7";
      if (pref && ((c[3] && c[2]) || (c[1] && c[0]))) return "R6";
      if (pref) return "R8";
      return "R5";
   endfunction

   // Monitor: pops one expected item per strobe
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R9", "strobe with nothing pending", 32'(res_valid), 32'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(cyc == e.tag + 1, "R9", "strobe cycle", 32'(cyc), 32'(e.tag + 1));
            check(res_fill == e.fill, e.req, "res_fill", 32'(res_fill), 32'(e.fill));
            check(res_way == e.way, e.req, "res_way", 32'(res_way), 32'(e.way));
         end
      end
   end

   task automatic write_cfg(input logic [4:0] c);
      logic [31:0] w, junk;
      junk = 32'hA5A5_A5A5 & ~32'h0001_0303;
      w = {15'd0, c[4], 6'd0, c[3], c[2], 6'd0, c[1], c[0]};
      @(negedge clk);
      acc_valid = 1'b0;
      cfg_wr_en = 1'b1;
      cfg_wdata = w | junk;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      cfg_wdata = 32'hFFFF_FFFF;
      #1;
      check(cfg_rdata == w, "R2", "readback", cfg_rdata, w);
   endtask

   task automatic drive(input logic [4:0] c, input bit pref, input bit hit,
                        input logic [1:0] hw, input logic [7:0] ord);
      logic [2:0] e;
      exp_t item;
      string r;
      @(negedge clk);
      acc_valid   = 1'b1;
      acc_is_pref = pref;
      acc_hit     = hit;
      acc_hit_way = hw;
      lru_order   = ord;
      #1;
      e = ref_dec(c, pref, hit, hw, ord);
      r = req_of(c, pref, hit);
      check(fill_need == e[2], r, "fill_need", 32'(fill_need), 32'(e[2]));
      check(fill_way == e[1:0], r, "fill_way", 32'(fill_way), 32'(e[1:0]));
      item.fill = e[2];
      item.way  = e[1:0];
      item.tag  = cyc;
      item.req  = r;
      sb.push_back(item);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         acc_valid = 1'b0;
         #1;
         check(fill_need == 1'b0, "R9", "fill_need idle", 32'(fill_need), 32'd0);
      end
   endtask

   logic [7:0] orders [5];

   initial begin
      orders[0] = 8'b11_10_01_00;
      orders[1] = 8'b00_01_10_11;
      orders[2] = 8'b00_01_11_10;
      orders[3] = 8'b01_00_10_11;
      orders[4] = 8'b10_11_00_01;

      // Reset state
      repeat (3) @(negedge clk);
      check(cfg_rdata == 32'd0, "R1", "cfg in reset", cfg_rdata, 32'd0);
      check(res_valid == 1'b0, "R1", "res_valid in reset", 32'(res_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(cfg_rdata == 32'd0, "R1", "cfg after reset", cfg_rdata, 32'd0);
      check(res_valid == 1'b0, "R1", "res_valid after reset", 32'(res_valid), 32'd0);

      // All writable bits plus junk
      @(negedge clk);
      cfg_wr_en = 1'b1;
      cfg_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      cfg_wdata = 32'h0;
      #1;
      check(cfg_rdata == 32'h0001_0303, "R2", "all-ones write", cfg_rdata, 32'h0001_0303);
      idle(2);
      check(cfg_rdata == 32'h0001_0303, "R2", "hold without write", cfg_rdata, 32'h0001_0303);

      // Full sweep: config x prefetch x hit/miss x order
      for (int c = 0; c < 32; c++) begin
         write_cfg(5'(c));
         for (int p = 0; p < 2; p++) begin
            for (int o = 0; o < 5; o++) begin
               drive(5'(c), p[0], 1'b0, 2'd0, orders[o]);
               for (int h = 0; h < 4; h++) begin
                  drive(5'(c), p[0], 1'b1, 2'(h), orders[o]);
               end
            end
            idle(1);
         end
      end

      // Explicit corner cases
      write_cfg(5'b1_1_1_0_0);
      drive(5'b1_1_1_0_0, 1'b1, 1'b1, 2'd0, orders[0]); // R3: way 0 hit blocks forced load
      drive(5'b1_1_1_1_1, 1'b0, 1'b0, 2'd0, orders[0]);
      idle(1);
      write_cfg(5'b1_1_1_1_1);
      drive(5'b1_1_1_1_1, 1'b1, 1'b0, 2'd0, orders[2]); // R7: way 3 wins
      drive(5'b1_1_1_1_1, 1'b0, 1'b0, 2'd0, orders[3]); // R5: both locked, way 0
      idle(3);

      check(sb.size() == 0, "R9", "pending results at end", 32'(sb.size()), 32'd0);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule